// File: doc/BRIEF.md
# Multiport RAM with Per-Pair Collision Masks

This block is a parameterised word-addressed storage array with `NW` write ports and `NR` read ports. All ports work from one clock, and a parameter chooses which edge of it is the active one. Every write port has a byte-free, per-bit write enable. When two write ports hit the same word in one cycle, a priority mask decides which port's bits land. Each read port is set at elaboration time to be either registered or combinational.

A registered read port has a read enable and an asynchronous reset and a synchronous reset, each with its own constant load value. It also has a power-up value for its output register. A per-port flag decides whether the read enable also gates the synchronous reset. For each pair of a read port and a write port, two mask bits describe what the read port returns when that write port writes the word being read in the same cycle. One bit selects the freshly written data. The other bit marks the result as undefined. With neither bit set, the read returns the stored word as it was before the write.

The block suits register files and multi-issue queues, where each port pair needs its own collision rule. The masks are plain vectors, so a wrapper can set them from its own configuration.

Top module: `mpram`

## Requirements
- R1: A write port stores `wr_data` bit b into word `wr_addr` at the active clock edge exactly when its `wr_en` bit b is 1. Bits whose enable is 0 keep their old value.
- R2: In parameter `WR_PRIO`, bit `i*NW+j` set means write port i wins over write port j. When both ports enable the same bit of the same word in one cycle, that bit takes port i's data. Bits that only one port enables take that port's data. The default sets only bit 2, so port 1 beats port 0.
- R3: A registered read port whose `RD_SYNC` bit is 1 loads the word at `rd_addr` into `rd_data` at the active edge when `rd_en` is 1. When `rd_en` is 0 and no reset applies, it holds its value.
- R4: In `RD_TRANS`, bit `r*NW+j` set makes registered read port r return write port j's newly written bits when both address the same word in one cycle. Bits that port j does not write come from storage. The default sets bits 0 and 1 (read port 0 sees both write ports).
- R5: When a registered read port collides with a write port and neither its transparency bit nor its collision-X bit for that port is set, it returns the word's value from before the write.
- R6: In `RD_CX`, bit `r*NW+j` set makes read port r's result undefined after a same-cycle collision with write port j. The stored data and the other read ports are unaffected. The default sets bit 3 (read port 1 against write port 1).
- R7: A read port whose `RD_SYNC` bit is 0 shows the word at `rd_addr` combinationally. Its `rd_en`, `rd_arst` and `rd_srst` have no effect. It is never transparent, and elaboration rejects set mask bits for it.
- R8: Before any clock edge or reset, a registered read port's output equals its `RD_INIT_VAL` slice. The defaults are 8'h0F for port 0 and 8'hF0 for port 1.
- R9: While `rd_arst[r]` is 1, registered read port r shows its `RD_ARST_VAL` slice (8'hA5 and 8'h5A by default). This overrides the enable and the synchronous reset.
- R10: When the port's `RD_CE_OVER_SRST` bit is 0 (port 0 by default), `rd_srst` loads the `RD_SRST_VAL` slice (8'h3C) at the edge whatever `rd_en` is.
- R11: When the port's `RD_CE_OVER_SRST` bit is 1 (port 1 by default), `rd_srst` loads the `RD_SRST_VAL` slice (8'hC3) only on edges where `rd_en` is 1. With `rd_en` at 0 the output holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock; the active edge is chosen by `CLK_RISE` |
| wr_en | input | NW*W | Per-bit write enables, one W-bit slice per write port |
| wr_addr | input | NW*AW | Word address per write port |
| wr_data | input | NW*W | Write data per write port |
| rd_en | input | NR | Read enable per read port (ignored for combinational ports) |
| rd_arst | input | NR | Asynchronous reset per read port, active high |
| rd_srst | input | NR | Synchronous reset per read port, active high |
| rd_addr | input | NR*AW | Word address per read port |
| rd_data | output | NR*W | Read data per read port |

## Verification
The checker relies on the read-port resets being treated as the only resets. Each registered-port property is switched off while that port's asynchronous reset is high. The properties hold only across a pulse that spans a whole clock period, so the stimulus keeps every reset high from one falling edge to the next. The transparency and priority properties assume full-word write enables and no competing write from the other port. The stimulus changes every input on the inactive edge and never lets two write ports collide without a priority bit between them. It checks nothing on a read port after a collision that its X mask marks as undefined. It first reloads that port through a normal read.

// File: rtl/mpram_pkg.sv
`timescale 1ns/1ps
package mpram_pkg;
   // true when n is a power of two and at least 2
   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

   // mask bit index for an (owner, other) pair
   function automatic int pair_idx(input int owner, input int other, input int n_other);
      return owner * n_other + other;
   endfunction
endpackage

// File: rtl/mpram_wr_arb.sv
`timescale 1ns/1ps
module mpram_wr_arb
   import mpram_pkg::*;
#(
   parameter int W  = 8,
   parameter int AW = 4,
   parameter int NW = 2,
   parameter logic [NW*NW-1:0] PRIO = '0
) (
   input  logic [NW-1:0][W-1:0]  wr_en,
   input  logic [NW-1:0][AW-1:0] wr_addr,
   output logic [NW-1:0][W-1:0]  keep
);
   // a bit survives unless a higher-priority port writes the same bit of the same word
   always_comb begin
      for (int i = 0; i < NW; i++) begin
         keep[i] = wr_en[i];
         for (int j = 0; j < NW; j++) begin
            if (j != i && PRIO[pair_idx(j, i, NW)] && wr_addr[j] == wr_addr[i])
               keep[i] = keep[i] & ~wr_en[j];
         end
      end
   end
endmodule

// File: rtl/mpram_rd_port.sv
`timescale 1ns/1ps
module mpram_rd_port #(
   parameter int W  = 8,
   parameter int AW = 4,
   parameter int NW = 2,
   parameter bit SYNC = 1'b1,
   parameter bit CE_OVER_SRST = 1'b0,
   parameter logic [NW-1:0] TRANS = '0,
   parameter logic [NW-1:0] CX = '0,
   parameter logic [W-1:0] ARST_VAL = '0,
   parameter logic [W-1:0] SRST_VAL = '0,
   parameter logic [W-1:0] INIT_VAL = '0
) (
   input  logic                  clk,
   input  logic                  en,
   input  logic                  arst,
   input  logic                  srst,
   input  logic [AW-1:0]         addr,
   input  logic [W-1:0]          raw,
   input  logic [NW-1:0][W-1:0]  wr_keep,
   input  logic [NW-1:0][AW-1:0] wr_addr,
   input  logic [NW-1:0][W-1:0]  wr_data,
   output logic [W-1:0]          q
);
   if (SYNC) begin : g_sync
      logic [W-1:0] fwd;
      logic [W-1:0] q_r = INIT_VAL;

      always_comb begin
         fwd = raw;
         for (int j = 0; j < NW; j++)
            if (TRANS[j] && wr_addr[j] == addr)
               fwd = (fwd & ~wr_keep[j]) | (wr_data[j] & wr_keep[j]);
         for (int j = 0; j < NW; j++)
            if (CX[j] && wr_addr[j] == addr && |wr_keep[j])
               fwd = 'x;
      end

      if (CE_OVER_SRST) begin : g_ce_gates_srst
         always_ff @(posedge clk or posedge arst) begin
            if (arst)    q_r <= ARST_VAL;
            else if (en) q_r <= srst ? SRST_VAL : fwd;
         end
      end else begin : g_srst_first
         always_ff @(posedge clk or posedge arst) begin
            if (arst)      q_r <= ARST_VAL;
            else if (srst) q_r <= SRST_VAL;
            else if (en)   q_r <= fwd;
         end
      end
      assign q = q_r;
   end else begin : g_comb
      logic unused_ctrl;
      assign unused_ctrl = ^{clk, en, arst, srst, wr_keep, wr_addr, wr_data};
      assign q = raw;
   end
endmodule

// File: rtl/mpram.sv
`timescale 1ns/1ps
module mpram
   import mpram_pkg::*;
#(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   parameter int NW    = 2,
   parameter int NR    = 3,
   parameter bit CLK_RISE = 1'b1,
   parameter logic [NW*NW-1:0] WR_PRIO  = 4'b0100,
   parameter logic [NR-1:0]    RD_SYNC  = 3'b011,
   parameter logic [NR*NW-1:0] RD_TRANS = 6'b000011,
   parameter logic [NR*NW-1:0] RD_CX    = 6'b001000,
   parameter logic [NR-1:0]    RD_CE_OVER_SRST = 3'b010,
   parameter logic [NR*W-1:0]  RD_ARST_VAL = 24'h00_5A_A5,
   parameter logic [NR*W-1:0]  RD_SRST_VAL = 24'h00_C3_3C,
   parameter logic [NR*W-1:0]  RD_INIT_VAL = 24'h00_F0_0F,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic                  clk,
   input  logic [NW-1:0][W-1:0]  wr_en,
   input  logic [NW-1:0][AW-1:0] wr_addr,
   input  logic [NW-1:0][W-1:0]  wr_data,
   input  logic [NR-1:0]         rd_en,
   input  logic [NR-1:0]         rd_arst,
   input  logic [NR-1:0]         rd_srst,
   input  logic [NR-1:0][AW-1:0] rd_addr,
   output logic [NR-1:0][W-1:0]  rd_data
);
   // elaboration-time parameter checks
   if (!is_pow2(DEPTH)) begin : g_bad_depth
      $error("mpram: DEPTH must be a power of two, at least 2");
   end
   for (genvar i = 0; i < NW; i++) begin : g_chk_prio
      if (WR_PRIO[i*NW+i]) begin : g_bad_self
         $error("mpram: a write port cannot have priority over itself");
      end
   end
   for (genvar r = 0; r < NR; r++) begin : g_chk_rd
      if (!RD_SYNC[r] && (RD_TRANS[r*NW +: NW] != '0 || RD_CX[r*NW +: NW] != '0)) begin : g_bad_async
         $error("mpram: a combinational read port takes no collision masks");
      end
   end

   logic eclk;
   assign eclk = CLK_RISE ? clk : ~clk;

   logic [NW-1:0][W-1:0] keep;

   mpram_wr_arb #(.W(W), .AW(AW), .NW(NW), .PRIO(WR_PRIO)) u_arb (
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .keep   (keep)
   );

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge eclk) begin
      for (int i = 0; i < NW; i++)
         for (int b = 0; b < W; b++)
            if (keep[i][b]) mem[wr_addr[i]][b] <= wr_data[i][b];
   end

   for (genvar r = 0; r < NR; r++) begin : g_rd
      logic [W-1:0] raw;
      assign raw = mem[rd_addr[r]];

      mpram_rd_port #(
         .W(W), .AW(AW), .NW(NW),
         .SYNC(RD_SYNC[r]),
         .CE_OVER_SRST(RD_CE_OVER_SRST[r]),
         .TRANS(RD_TRANS[r*NW +: NW]),
         .CX(RD_CX[r*NW +: NW]),
         .ARST_VAL(RD_ARST_VAL[r*W +: W]),
         .SRST_VAL(RD_SRST_VAL[r*W +: W]),
         .INIT_VAL(RD_INIT_VAL[r*W +: W])
      ) u_port (
         .clk    (eclk),
         .en     (rd_en[r]),
         .arst   (rd_arst[r]),
         .srst   (rd_srst[r]),
         .addr   (rd_addr[r]),
         .raw    (raw),
         .wr_keep(keep),
         .wr_addr(wr_addr),
         .wr_data(wr_data),
         .q      (rd_data[r])
      );
   end
endmodule

// File: rtl/mpram_chk.sv
`timescale 1ns/1ps
module mpram_chk #(
   parameter int W = 8,
   parameter int AW = 4,
   parameter int NW = 2,
   parameter int NR = 3,
   parameter bit CLK_RISE = 1'b1,
   parameter logic [NW*NW-1:0] WR_PRIO  = '0,
   parameter logic [NR-1:0]    RD_SYNC  = '0,
   parameter logic [NR*NW-1:0] RD_TRANS = '0,
   parameter logic [NR*NW-1:0] RD_CX    = '0,
   parameter logic [NR-1:0]    RD_CE_OVER_SRST = '0,
   parameter logic [NR*W-1:0]  RD_ARST_VAL = '0,
   parameter logic [NR*W-1:0]  RD_SRST_VAL = '0
) (
   input logic                  clk,
   input logic [NW-1:0][W-1:0]  wr_en,
   input logic [NW-1:0][AW-1:0] wr_addr,
   input logic [NW-1:0][W-1:0]  wr_data,
   input logic [NR-1:0]         rd_en,
   input logic [NR-1:0]         rd_arst,
   input logic [NR-1:0]         rd_srst,
   input logic [NR-1:0][AW-1:0] rd_addr,
   input logic [NR-1:0][W-1:0]  rd_data
);
   logic ck;
   assign ck = CLK_RISE ? clk : ~clk;

   for (genvar r = 0; r < NR; r++) begin : g_port
      if (RD_SYNC[r]) begin : g_sync
         // R9: reset held across an edge shows the reset value
         assert_arst_value_R9: assert property (@(posedge ck) disable iff (!rd_arst[r])
            $past(rd_arst[r]) |-> rd_data[r] == RD_ARST_VAL[r*W +: W]);

         if (RD_CE_OVER_SRST[r]) begin : g_ce_srst
            // R11: reset without enable leaves the output alone
            assert_srst_gated_R11: assert property (@(posedge ck) disable iff (rd_arst[r])
               rd_srst[r] && !rd_en[r] |=> $stable(rd_data[r]));
            assert_srst_taken_R11: assert property (@(posedge ck) disable iff (rd_arst[r])
               rd_srst[r] && rd_en[r] |=> rd_data[r] == RD_SRST_VAL[r*W +: W]);
         end else begin : g_plain_srst
            // R10: reset applies regardless of enable
            assert_srst_value_R10: assert property (@(posedge ck) disable iff (rd_arst[r])
               rd_srst[r] |=> rd_data[r] == RD_SRST_VAL[r*W +: W]);
            // R3: idle port holds
            assert_hold_R3: assert property (@(posedge ck) disable iff (rd_arst[r])
               !rd_en[r] && !rd_srst[r] |=> $stable(rd_data[r]));
         end
      end
   end

   if (NW == 2 && RD_SYNC[0] && RD_TRANS[0] && !RD_CX[0]) begin : g_trans
      // R4: full-word write seen by a transparent read in the same cycle
      assert_transparent_R4: assert property (@(posedge ck) disable iff (rd_arst[0])
         rd_en[0] && !rd_srst[0] && (&wr_en[0]) && wr_addr[0] == rd_addr[0]
         && !(wr_addr[1] == rd_addr[0] && |wr_en[1])
         |=> rd_data[0] == $past(wr_data[0]));
   end

   if (NW == 2 && NR == 3 && !RD_SYNC[2] && WR_PRIO[2] && !WR_PRIO[1]) begin : g_prio
      // R2: port 1 wins a full-word collision, seen through the combinational port
      assert_prio_R2: assert property (@(posedge ck) disable iff (rd_arst[0])
         (&wr_en[0]) && (&wr_en[1]) && wr_addr[0] == wr_addr[1]
         |=> (rd_addr[2] != $past(wr_addr[1]) || rd_data[2] == $past(wr_data[1])));
   end
endmodule

bind mpram mpram_chk #(
   .W(W), .AW(AW), .NW(NW), .NR(NR), .CLK_RISE(CLK_RISE),
   .WR_PRIO(WR_PRIO), .RD_SYNC(RD_SYNC), .RD_TRANS(RD_TRANS), .RD_CX(RD_CX),
   .RD_CE_OVER_SRST(RD_CE_OVER_SRST), .RD_ARST_VAL(RD_ARST_VAL), .RD_SRST_VAL(RD_SRST_VAL)
) u_chk (
   .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .rd_en(rd_en), .rd_arst(rd_arst), .rd_srst(rd_srst),
   .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/mpram_bench.sv
`timescale 1ns/1ps
module mpram_bench;
   localparam int W = 8, NW = 2, NR = 3, AW = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [NW-1:0][W-1:0]  wr_en   = '0;
   logic [NW-1:0][AW-1:0] wr_addr = '0;
   logic [NW-1:0][W-1:0]  wr_data = '0;
   logic [NR-1:0]         rd_en   = '0;
   logic [NR-1:0]         rd_arst = '0;
   logic [NR-1:0]         rd_srst = '0;
   logic [NR-1:0][AW-1:0] rd_addr = '0;
   logic [NR-1:0][W-1:0]  rd_data;

   mpram u_mpram (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_arst(rd_arst), .rd_srst(rd_srst),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   int           q_port[$];
   logic [W-1:0] q_val[$];
   string        q_tag[$];

   task automatic check(input logic ok, input string tag, input logic [W-1:0] got, input logic [W-1:0] want);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, want);
      end
   endtask

   // driver side: expectation for the result after the coming active edge
   task automatic expect_rd(input int p, input logic [W-1:0] v, input string tag);
      q_port.push_back(p);
      q_val.push_back(v);
      q_tag.push_back(tag);
   endtask

   // start a cycle on the falling edge with all controls idle
   task automatic cyc();
      @(negedge clk);
      wr_en = '0;
      rd_en = '0;
      rd_srst = '0;
      rd_arst = '0;
   endtask

   // monitor: compare queued expectations shortly after each active edge
   always @(posedge clk) begin
      #2;
      while (q_port.size() > 0) begin
         int p;
         logic [W-1:0] v;
         string t;
         p = q_port.pop_front();
         v = q_val.pop_front();
         t = q_tag.pop_front();
         check(rd_data[p] === v, t, rd_data[p], v);
      end
   end

   initial begin
      #1;
      check(rd_data[0] === 8'h0F, "R8 port0 power-up", rd_data[0], 8'h0F);
      check(rd_data[1] === 8'hF0, "R8 port1 power-up", rd_data[1], 8'hF0);

      cyc(); rd_arst[1:0] = 2'b11;
      expect_rd(0, 8'hA5, "R9 port0 async reset");
      expect_rd(1, 8'h5A, "R9 port1 async reset");

      // fill: word k = 3k+1
      for (int k = 0; k < 16; k++) begin
         cyc();
         wr_en[0] = '1; wr_addr[0] = AW'(k); wr_data[0] = W'(3 * k + 1);
      end

      cyc(); rd_addr[2] = 4'd5;
      rd_en[0] = 1; rd_addr[0] = 4'd7; rd_en[1] = 1; rd_addr[1] = 4'd7;
      expect_rd(2, 8'h10, "R7 combinational read");
      expect_rd(0, 8'h16, "R3 port0 read");
      expect_rd(1, 8'h16, "R3 port1 read");

      cyc(); rd_addr[0] = 4'd3; rd_addr[1] = 4'd3;
      expect_rd(0, 8'h16, "R3 port0 hold");
      expect_rd(1, 8'h16, "R3 port1 hold");

      cyc(); wr_en[0] = '1; wr_addr[0] = 4'd9; wr_data[0] = 8'hEE;
      rd_en[0] = 1; rd_addr[0] = 4'd9; rd_en[1] = 1; rd_addr[1] = 4'd9;
      expect_rd(0, 8'hEE, "R4 transparent read");
      expect_rd(1, 8'h1C, "R5 read-old on collision");

      cyc(); rd_addr[2] = 4'd9;
      wr_en[0] = 8'h0F; wr_addr[0] = 4'd2; wr_data[0] = 8'hAB;
      rd_en[0] = 1; rd_addr[0] = 4'd2;
      expect_rd(2, 8'hEE, "R1 stored write");
      expect_rd(0, 8'h0B, "R4 partial transparent merge");

      cyc(); rd_addr[2] = 4'd2;
      wr_en[0] = '1; wr_addr[0] = 4'd4; wr_data[0] = 8'h11;
      wr_en[1] = '1; wr_addr[1] = 4'd4; wr_data[1] = 8'h22;
      rd_en[0] = 1; rd_addr[0] = 4'd4;
      expect_rd(2, 8'h0B, "R1 per-bit enable");
      expect_rd(0, 8'h22, "R2 transparent read follows winner");

      cyc(); rd_addr[2] = 4'd4;
      wr_en[0] = 8'hFF; wr_addr[0] = 4'd6; wr_data[0] = 8'h05;
      wr_en[1] = 8'hF0; wr_addr[1] = 4'd6; wr_data[1] = 8'h90;
      expect_rd(2, 8'h22, "R2 full-word priority");

      cyc(); rd_addr[2] = 4'd6;
      wr_en[1] = '1; wr_addr[1] = 4'd10; wr_data[1] = 8'h77;
      rd_en[1] = 1; rd_addr[1] = 4'd10;   // port1 undefined here: not checked
      rd_en[0] = 1; rd_addr[0] = 4'd10;
      expect_rd(2, 8'h95, "R2 bitwise priority merge");
      expect_rd(0, 8'h77, "R6 other port unaffected by X collision");

      cyc(); rd_addr[2] = 4'd10; rd_en[1] = 1; rd_addr[1] = 4'd5;
      expect_rd(2, 8'h77, "R6 storage unaffected by X collision");
      expect_rd(1, 8'h10, "R3 port1 reload");

      cyc(); rd_srst[0] = 1; rd_srst[1] = 1;
      expect_rd(0, 8'h3C, "R10 sync reset without enable");
      expect_rd(1, 8'h10, "R11 sync reset gated by enable");

      cyc(); rd_srst[0] = 1; rd_en[0] = 1; rd_addr[0] = 4'd7;
      rd_srst[1] = 1; rd_en[1] = 1;
      expect_rd(0, 8'h3C, "R10 sync reset beats enable");
      expect_rd(1, 8'hC3, "R11 sync reset with enable");

      cyc(); rd_arst[0] = 1; rd_srst[0] = 1; rd_en[0] = 1;
      rd_arst[1] = 1; rd_en[1] = 1;
      expect_rd(0, 8'hA5, "R9 async reset overrides");
      expect_rd(1, 8'h5A, "R9 async reset overrides port1");

      cyc(); rd_en[0] = 1; rd_addr[0] = 4'd7; rd_addr[2] = 4'd2;
      rd_arst[2] = 1; rd_srst[2] = 1;
      expect_rd(0, 8'h16, "R3 read after reset release");
      expect_rd(2, 8'h0B, "R7 controls ignored on combinational port");

      cyc(); cyc();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule